// File: doc/BRIEF.md
# Bus Tenure Arbitration Controller

This controller decides, on every bus clock, how the local processor relates to a shared bus. The processor can own the bus while idle (parked on it by the grant), own it while actively running transfers, or be handing the bus back. Another master can hold the bus while idle or while driving transfers. Two further states cover a cycle that services a snoop from another master, and a cycle that records a protocol violation. In the violation case, another master started a transfer while the local master still held the bus.

The controller watches the grant, the relinquish-control qualifier, transfer starts and tenure terminations driven by other masters, the snoop request with its transfer-type qualifier, the internal request and the end-of-cycle indication. It drives the registered bus request, a one-hot status word, an ownership flag, a tenure-end strobe, a snoop-accept strobe and a violation flag. Locked sequences keep the bus after the grant is withdrawn. Snoop acceptance is rate limited.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: While `rst` is high the status word is 8'h01, `bus_req` is 0 and `bus_owned` is 0. Status bit positions are: 0 reset, 1 implicit own, 2 explicit own, 3 ending tenure, 4 other-master implicit, 5 other-master explicit, 6 snoop, 7 violation.
- R2: On the first clock after `rst` falls, the state becomes implicit own (8'h02) if `grant` is high, and other-master implicit (8'h10) if it is low.
- R3: `bus_req` equals the value `int_req` had one clock earlier.
- R4: In implicit own, a foreign transfer start has top priority, then a low `grant` moves to other-master implicit, then a high `int_req` moves to explicit own.
- R5: In explicit own, a transfer end moves to ending tenure when `grant` is low. When `grant` is high and `int_req` is low, it moves to implicit own instead.
- R6: `cyc_end` has no effect while `line_more` is high, because the long-word pieces of one line transfer form a single transfer.
- R7: In explicit own, with `grant` low, `lock_act` high and `relinq_ok` low, a transfer end does not leave explicit own.
- R8: Ending tenure lasts one clock, or one extra clock when `lock_act` was high on entry. `tenure_end` is high in its final clock, and the next state is other-master implicit.
- R9: In other-master implicit, a high `grant` enters explicit own if `int_req` is high and implicit own otherwise. Else an accepted snoop enters snoop, else a foreign transfer start enters other-master explicit. In other-master explicit, an accepted snoop comes first. Otherwise `btt_seen` leaves: to an own state chosen as above if `grant` is high, else to other-master implicit.
- R10: A snoop counts only when `snoop_req` is 1 and `tt1` is 0. The snoop state lasts one clock and returns to other-master explicit.
- R11: Two snoop accepts (`snoop_take`) are never closer than SNOOP_GAP clocks (default 2). A snoop request held high therefore alternates snoop and other-master explicit.
- R12: A foreign transfer start seen in either own state enters violation (8'h80, `violation` high) for one clock, then other-master explicit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Asynchronous reset, active high |
| grant | input | 1 | Bus grant to this master |
| relinq_ok | input | 1 | High allows giving the bus up during a locked sequence |
| ts_seen | input | 1 | Transfer start driven by another master |
| btt_seen | input | 1 | Tenure termination driven by another master |
| snoop_req | input | 1 | Snoop request |
| tt1 | input | 1 | Transfer-type qualifier; a snoop counts only when it is 0 |
| int_req | input | 1 | Internal request for the bus |
| cyc_end | input | 1 | Transfer terminated (normal, error or retry) |
| line_more | input | 1 | More long-word pieces of the same line follow |
| lock_act | input | 1 | Locked sequence active |
| bus_req | output | 1 | Registered bus request |
| state_oh | output | 8 | One-hot state status |
| bus_owned | output | 1 | This master holds the bus (own or ending tenure) |
| tenure_end | output | 1 | Final clock of ending tenure |
| snoop_take | output | 1 | Snoop accepted this clock |
| violation | output | 1 | Violation state active |

## Verification
The embedded properties check on every clock the following rules:
- the one-clock delay of the request;
- where the violation state can be entered from;
- the lock hold;
- the extra ending-tenure clock and the exit that follows it;
- the single-clock snoop state;
- the minimum spacing of snoop accepts.

Only the directed scenarios show the following:
- the exact state chosen after reset;
- the priorities among grant, snoop and transfer start;
- the filtering of `tt1` and `line_more`;
- that reset works from the middle of a transfer.

// File: rtl/bus_tenure_pkg.sv
package bus_tenure_pkg;

  localparam int NSTATE = 8;

  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_IOWN = 3'd1,
    ST_XOWN = 3'd2,
    ST_ENDT = 3'd3,
    ST_AMI  = 3'd4,
    ST_AMX  = 3'd5,
    ST_SNP  = 3'd6,
    ST_VIOL = 3'd7
  } tstate_e;

  // one-hot status image of a state
  function automatic logic [NSTATE-1:0] state_bits(tstate_e s);
    logic [NSTATE-1:0] r;
    r = '0;
    r[s] = 1'b1;
    return r;
  endfunction

  // own state to enter when the grant arrives
  function automatic tstate_e own_entry(logic req);
    return req ? ST_XOWN : ST_IOWN;
  endfunction

  // length extension of ending tenure
  function automatic int unsigned end_extra(logic locked, int unsigned extra);
    return locked ? extra : 0;
  endfunction

endpackage

// File: rtl/btc_req_reg.sv
module btc_req_reg #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES:0] pipe;
  assign pipe[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) pipe[i+1] <= 1'b0;
      else     pipe[i+1] <= pipe[i];
    end
  end

  assign q = pipe[STAGES];

  if (STAGES == 1) begin : g_chk
    // R3
    req_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (q == $past(d)));
  end
endmodule

// File: rtl/btc_snoop_gate.sv
module btc_snoop_gate #(
  parameter int SNOOP_GAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic snoop_req,
  input  logic tt1,
  input  logic take,
  output logic hit
);
  localparam int CW = (SNOOP_GAP > 1) ? $clog2(SNOOP_GAP) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SNOOP_GAP - 1);

  logic [CW-1:0] hold_cnt;
  logic          cool;

  assign cool = (hold_cnt == '0);
  assign hit  = snoop_req & ~tt1 & cool;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 hold_cnt <= '0;
    else if (take)           hold_cnt <= RELOAD;
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  if (SNOOP_GAP >= 2) begin : g_chk
    // R11
    snoop_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      take |=> !take);
  end
endmodule

// File: rtl/btc_fsm.sv
module btc_fsm
  import bus_tenure_pkg::*;
#(
  parameter int LOCK_EXTRA = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    grant,
  input  logic    relinq_ok,
  input  logic    ts_seen,
  input  logic    btt_seen,
  input  logic    snoop_hit,
  input  logic    int_req,
  input  logic    cyc_end,
  input  logic    line_more,
  input  logic    lock_act,
  output tstate_e cur,
  output logic    tenure_end,
  output logic    snoop_take
);
  localparam int EW = (LOCK_EXTRA > 0) ? $clog2(LOCK_EXTRA + 1) : 1;

  tstate_e       nxt;
  logic [EW-1:0] end_cnt;
  logic          tx_done;
  logic          lock_hold;
  logic          end_enter;

  // a line split into long-words ends only with its last piece
  assign tx_done   = cyc_end & ~line_more;
  assign lock_hold = lock_act & ~relinq_ok;
  assign end_enter = (nxt == ST_ENDT) && (cur != ST_ENDT);

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_RST:  nxt = grant ? ST_IOWN : ST_AMI;
      ST_IOWN: begin
        if (ts_seen)     nxt = ST_VIOL;
        else if (!grant) nxt = ST_AMI;
        else if (int_req) nxt = ST_XOWN;
      end
      ST_XOWN: begin
        if (ts_seen) nxt = ST_VIOL;
        else if (tx_done) begin
          if (!grant && !lock_hold)  nxt = ST_ENDT;
          else if (grant && !int_req) nxt = ST_IOWN;
        end
      end
      ST_ENDT: if (end_cnt == '0) nxt = ST_AMI;
      ST_AMI: begin
        if (grant)          nxt = own_entry(int_req);
        else if (snoop_hit) nxt = ST_SNP;
        else if (ts_seen)   nxt = ST_AMX;
      end
      ST_AMX: begin
        if (snoop_hit)     nxt = ST_SNP;
        else if (btt_seen) nxt = grant ? own_entry(int_req) : ST_AMI;
      end
      ST_SNP:  nxt = ST_AMX;
      ST_VIOL: nxt = ST_AMX;
      default: nxt = ST_RST;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cur <= ST_RST;
    else     cur <= nxt;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                                end_cnt <= '0;
    else if (end_enter)                     end_cnt <= EW'(end_extra(lock_act, LOCK_EXTRA));
    else if (cur == ST_ENDT && end_cnt != '0) end_cnt <= end_cnt - 1'b1;
  end

  assign tenure_end = (cur == ST_ENDT) && (end_cnt == '0);
  assign snoop_take = (nxt == ST_SNP);

  // R12
  violation_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cur == ST_VIOL) |-> $past(cur == ST_IOWN || cur == ST_XOWN));
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_XOWN && !grant && lock_act && !relinq_ok && !ts_seen) |=> (cur == ST_XOWN));
  // R8
  end_extra_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_ENDT && end_cnt != '0) |=> (cur == ST_ENDT));
  // R8
  end_exit_chk: assert property (@(posedge clk) disable iff (rst)
    tenure_end |=> (cur == ST_AMI));
  // R10
  snoop_one_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_SNP) |=> (cur == ST_AMX));
endmodule

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl
  import bus_tenure_pkg::*;
#(
  parameter int SNOOP_GAP  = 2,
  parameter int LOCK_EXTRA = 1,
  parameter int REQ_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              relinq_ok,
  input  logic              ts_seen,
  input  logic              btt_seen,
  input  logic              snoop_req,
  input  logic              tt1,
  input  logic              int_req,
  input  logic              cyc_end,
  input  logic              line_more,
  input  logic              lock_act,
  output logic              bus_req,
  output logic [NSTATE-1:0] state_oh,
  output logic              bus_owned,
  output logic              tenure_end,
  output logic              snoop_take,
  output logic              violation
);
  tstate_e cur;
  logic    snoop_hit;

  btc_req_reg #(.STAGES(REQ_STAGES)) u_req (
    .clk(clk), .rst(rst), .d(int_req), .q(bus_req)
  );

  btc_snoop_gate #(.SNOOP_GAP(SNOOP_GAP)) u_gate (
    .clk(clk), .rst(rst), .snoop_req(snoop_req), .tt1(tt1),
    .take(snoop_take), .hit(snoop_hit)
  );

  btc_fsm #(.LOCK_EXTRA(LOCK_EXTRA)) u_fsm (
    .clk(clk), .rst(rst), .grant(grant), .relinq_ok(relinq_ok),
    .ts_seen(ts_seen), .btt_seen(btt_seen), .snoop_hit(snoop_hit),
    .int_req(int_req), .cyc_end(cyc_end), .line_more(line_more),
    .lock_act(lock_act), .cur(cur), .tenure_end(tenure_end),
    .snoop_take(snoop_take)
  );

  assign state_oh  = state_bits(cur);
  assign bus_owned = (cur == ST_IOWN) || (cur == ST_XOWN) || (cur == ST_ENDT);
  assign violation = (cur == ST_VIOL);

  // R1
  owned_status_chk: assert property (@(posedge clk) disable iff (rst)
    bus_owned |-> !state_oh[0] && !state_oh[4] && !state_oh[5]);
endmodule

// File: tb/bus_tenure_ctrl_bench.sv
module bus_tenure_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 0, relinq_ok = 1, ts_seen = 0, btt_seen = 0;
  logic snoop_req = 0, tt1 = 0, int_req = 0, cyc_end = 0, line_more = 0, lock_act = 0;
  logic       bus_req, bus_owned, tenure_end, snoop_take, violation;
  logic [7:0] state_oh;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] S_RST = 8'h01, S_IOWN = 8'h02, S_XOWN = 8'h04, S_ENDT = 8'h08,
                         S_AMI = 8'h10, S_AMX = 8'h20, S_SNP = 8'h40, S_VIOL = 8'h80;

  always #5 clk = ~clk;

  bus_tenure_ctrl u_bus_tenure_ctrl (
    .clk(clk), .rst(rst), .grant(grant), .relinq_ok(relinq_ok),
    .ts_seen(ts_seen), .btt_seen(btt_seen), .snoop_req(snoop_req), .tt1(tt1),
    .int_req(int_req), .cyc_end(cyc_end), .line_more(line_more), .lock_act(lock_act),
    .bus_req(bus_req), .state_oh(state_oh), .bus_owned(bus_owned),
    .tenure_end(tenure_end), .snoop_take(snoop_take), .violation(violation)
  );

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    grant = 0; relinq_ok = 1; ts_seen = 0; btt_seen = 0; snoop_req = 0;
    tt1 = 0; int_req = 0; cyc_end = 0; line_more = 0; lock_act = 0;
  endtask

  task automatic restart(logic g);
    quiet();
    rst = 1; step();
    grant = g; rst = 0; step();
  endtask

  task automatic t_reset();
    quiet(); int_req = 1; rst = 1; step(); step();
    chk("R1", "state", state_oh, S_RST);
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "owned", bus_owned, 0);
  endtask

  task automatic t_exit_reset();
    restart(0);
    chk("R2", "no grant", state_oh, S_AMI);
    restart(1);
    chk("R2", "grant", state_oh, S_IOWN);
    chk("R1", "owned", bus_owned, 1);
  endtask

  task automatic t_request();
    restart(1);
    int_req = 1; step();
    chk("R4", "to explicit", state_oh, S_XOWN);
    chk("R3", "req high", bus_req, 1);
    int_req = 0; step();
    chk("R3", "req low", bus_req, 0);
    chk("R4", "holds explicit", state_oh, S_XOWN);
  endtask

  task automatic t_release();
    restart(1);
    int_req = 1; step();
    grant = 0; cyc_end = 1; line_more = 1; step();
    chk("R6", "line piece", state_oh, S_XOWN);
    line_more = 0; step();
    chk("R5", "to ending", state_oh, S_ENDT);
    chk("R8", "strobe", tenure_end, 1);
    cyc_end = 0; step();
    chk("R8", "after end", state_oh, S_AMI);
    chk("R8", "strobe off", tenure_end, 0);
  endtask

  task automatic t_lock();
    restart(1);
    int_req = 1; step();
    grant = 0; lock_act = 1; relinq_ok = 0; cyc_end = 1; step();
    chk("R7", "lock hold", state_oh, S_XOWN);
    relinq_ok = 1; step();
    chk("R8", "ending locked", state_oh, S_ENDT);
    chk("R8", "no strobe yet", tenure_end, 0);
    cyc_end = 0; lock_act = 0; step();
    chk("R8", "extra clock", state_oh, S_ENDT);
    chk("R8", "strobe", tenure_end, 1);
    step();
    chk("R8", "after end", state_oh, S_AMI);
  endtask

  task automatic t_park();
    restart(1);
    int_req = 1; step();
    int_req = 0; cyc_end = 1; step();
    chk("R5", "to implicit", state_oh, S_IOWN);
    cyc_end = 0; grant = 0; int_req = 1; step();
    chk("R4", "grant gone", state_oh, S_AMI);
  endtask

  task automatic t_snoop();
    restart(0);
    ts_seen = 1; step();
    chk("R9", "foreign start", state_oh, S_AMX);
    ts_seen = 0; snoop_req = 1; tt1 = 1; step();
    chk("R10", "tt1 filtered", state_oh, S_AMX);
    tt1 = 0; step();
    chk("R10", "snoop", state_oh, S_SNP);
    step();
    chk("R11", "gap", state_oh, S_AMX);
    step();
    chk("R11", "again", state_oh, S_SNP);
    snoop_req = 0; btt_seen = 1; step();
    chk("R10", "return", state_oh, S_AMX);
    step();
    chk("R9", "btt no grant", state_oh, S_AMI);
    btt_seen = 0; grant = 1; int_req = 1; snoop_req = 1; step();
    chk("R9", "grant over snoop", state_oh, S_XOWN);
  endtask

  task automatic t_violation();
    restart(1);
    ts_seen = 1; step();
    chk("R12", "state", state_oh, S_VIOL);
    chk("R12", "flag", violation, 1);
    ts_seen = 0; step();
    chk("R12", "after", state_oh, S_AMX);
    btt_seen = 1; step();
    chk("R9", "btt with grant", state_oh, S_IOWN);
    btt_seen = 0; int_req = 1; step();
    rst = 1; #1;
    chk("R1", "mid reset", state_oh, S_RST);
    chk("R1", "mid bus_req", bus_req, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_exit_reset();
    t_request();
    t_release();
    t_lock();
    t_park();
    t_snoop();
    t_violation();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule